// File: doc/BRIEF.md
# Segmented Address Translator with Hashed Page Table Walk

This block turns a 32-bit effective address into a real address. The top four address bits pick one of sixteen segment registers. The selected register supplies a 24-bit virtual segment identifier, two protection keys and a no-execute flag. A 64-entry direct-mapped page TLB is looked up first. On a TLB miss, the block searches a page table held in memory. The search reads candidate entries over a simple word memory port. It also writes the referenced and changed bits back into the table entry as a side effect.

A request is taken only while the block is idle. It ends with a one-cycle `done` pulse that carries either the real address or a fault code. Segment registers are written through a dedicated port. Single TLB entries are cleared by index, and the whole TLB can be cleared at once. The table origin and the hash mask are static configuration inputs.

Top module: `hashed_xlate`

## Requirements
- R1: `sr_wdata` holds the segment fields as: bit 26 supervisor key, bit 25 user key, bit 24 no-execute, bits 23:0 segment ID. `req_ea[31:28]` selects the register used for a request.
- R2: An instruction fetch (`req_acc`=2) through a segment with no-execute set ends with fault code 1 (protection) and no memory access.
- R3: The TLB is indexed by EA[17:12]. It hits when the stored segment ID equals the current one and the stored page index equals EA[27:12]. A hit makes no table reads.
- R4: The primary hash is segment ID[18:0] XOR EA[27:12]. The group address is `cfg_origin` OR ((hash AND `cfg_mask`) << 6). The second pass uses the bitwise inverse of the hash. Each pass reads eight 8-byte entries in rising address order, reading word 0 at the entry address.
- R5: Word 0 of an entry matches when bit 31 (valid) is set, bit 6 equals the pass number (0 first, 1 second), bits 30:7 equal the segment ID and bits 5:0 equal EA[27:22].
- R6: On a match, word 1 (entry address + 4) is read. Its fields are: bits 31:12 real page number, bit 8 referenced, bit 7 changed, bits 1:0 protection. If the referenced bit is clear, word 1 is written back with bit 8 set.
- R7: The key is the supervisor key when `problem_state`=0 and the user key otherwise. With key 0, protection 11 forbids writes and all other values allow everything. With key 1: 00 forbids everything, 10 allows everything, and 01 and 11 forbid writes. A denied access gives fault 1.
- R8: A permitted write (`req_acc`=1) to a page whose cached changed bit is clear re-reads word 1 and writes it back with bit 7 set. Later writes to the same cached page make no memory access.
- R9: A successful translation gives fault 0 and a real address of {real page number, EA[11:0]}. If neither pass matches, the result is fault 2 (table miss).
- R10: `inv_one` clears the TLB entry at index `inv_idx`, leaving the other entries intact. `inv_all` clears every entry.
- R11: A request presented while a translation is in progress is ignored. Each accepted request yields exactly one single-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_ea | input | 32 | Effective address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| problem_state | input | 1 | 1 selects the user key |
| cfg_origin | input | 32 | Page table origin |
| cfg_mask | input | 19 | Hash mask |
| sr_we | input | 1 | Segment register write strobe |
| sr_idx | input | 4 | Segment register number |
| sr_wdata | input | 27 | Segment register value |
| inv_one | input | 1 | Clear one TLB entry |
| inv_all | input | 1 | Clear all TLB entries |
| inv_idx | input | 6 | TLB index to clear (EA[17:12]) |
| mem_req | output | 1 | Memory access request, held until ack |
| mem_we | output | 1 | 1 for a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle completion |
| mem_rdata | input | 32 | Read data, valid with ack |
| done | output | 1 | Result pulse |
| ra | output | 32 | Real address |
| fault | output | 2 | 0 none, 1 protection, 2 table miss |

## Verification
The assertions assume that segment register writes, invalidates and configuration changes happen only while the block is idle. They also assume the memory returns one ack per request and never acks when no request is pending, and that the table is changed only between requests. The stimulus meets these assumptions by driving every control input from one sequence. That sequence waits for each `done` before the next action. A single memory responder with a fixed latency serves the port. The one deliberate exception is a second request raised during a walk, which the block must drop.

// File: rtl/hx_pkg.sv
package hx_pkg;
  localparam int EA_W    = 32;
  localparam int VSID_W  = 24;
  localparam int HASH_W  = 19;
  localparam int PAGE_W  = 16;
  localparam int RPN_W   = EA_W - 12;
  localparam int SEG_N   = 16;
  localparam int SEG_IW  = $clog2(SEG_N);
  localparam int SEG_BW  = VSID_W + 3;
  localparam int TLB_N   = 64;
  localparam int TLB_IW  = $clog2(TLB_N);
  localparam int SLOTS   = 8;
  localparam int SLOT_IW = $clog2(SLOTS);
  localparam int REF_BIT = 8;
  localparam int CHG_BIT = 7;
  localparam int HSEL_BIT = 6;

  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2} acc_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_PROT = 2'd1, FLT_MISS = 2'd2} flt_e;
  typedef enum logic [3:0] {S_IDLE, S_CHECK, S_RD0, S_RD1, S_WRR, S_PERM, S_RDC, S_WRC} st_e;

  typedef struct packed {
    logic              ks;
    logic              ku;
    logic              nx;
    logic [VSID_W-1:0] vsid;
  } seg_t;

  typedef struct packed {
    logic [VSID_W-1:0] vsid;
    logic [PAGE_W-1:0] page;
    logic [RPN_W-1:0]  rpn;
    logic              chg;
    logic [1:0]        pp;
    logic [EA_W-1:0]   w1_addr;
  } tlb_t;

  function automatic logic [HASH_W-1:0] f_hash(input logic [VSID_W-1:0] vsid,
                                                input logic [PAGE_W-1:0] page,
                                                input logic sec);
    logic [HASH_W-1:0] h;
    h = vsid[HASH_W-1:0] ^ HASH_W'(page);
    return sec ? ~h : h;
  endfunction

  function automatic logic [EA_W-1:0] f_group(input logic [EA_W-1:0] origin,
                                               input logic [HASH_W-1:0] mask,
                                               input logic [HASH_W-1:0] h);
    return origin | (EA_W'(h & mask) << 6);
  endfunction

  function automatic logic f_pte_match(input logic [31:0] w0,
                                       input logic [VSID_W-1:0] vsid,
                                       input logic [5:0] api,
                                       input logic pass);
    return w0[31] && (w0[HSEL_BIT] == pass) && (w0[30:7] == vsid) && (w0[5:0] == api);
  endfunction

  function automatic logic f_allowed(input logic key, input logic [1:0] pp, input acc_e acc);
    if (!key) return !(pp == 2'b11 && acc == ACC_WRITE);
    case (pp)
      2'b00:   return 1'b0;
      2'b10:   return 1'b1;
      default: return acc != ACC_WRITE;
    endcase
  endfunction
endpackage

// File: rtl/hx_seg_file.sv
module hx_seg_file import hx_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEG_IW-1:0] widx,
  input  logic [SEG_BW-1:0] wdata,
  input  logic [SEG_IW-1:0] ridx,
  output seg_t              rd
);
  seg_t sr [SEG_N];

  for (genvar g = 0; g < SEG_N; g++) begin : g_sr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr[g] <= '0;
      else if (we && widx == SEG_IW'(g)) sr[g] <= seg_t'(wdata);
    end
  end

  assign rd = sr[ridx];
endmodule

// File: rtl/hx_page_tlb.sv
module hx_page_tlb import hx_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TLB_IW-1:0] rd_idx,
  output logic              rd_vld,
  output tlb_t              rd_ent,
  input  logic              fill_en,
  input  logic [TLB_IW-1:0] fill_idx,
  input  tlb_t              fill_ent,
  input  logic              chg_en,
  input  logic [TLB_IW-1:0] chg_idx,
  input  logic              inv_one,
  input  logic [TLB_IW-1:0] inv_idx,
  input  logic              inv_all
);
  logic vld [TLB_N];
  tlb_t ent [TLB_N];

  for (genvar g = 0; g < TLB_N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld[g] <= 1'b0;
      else if (inv_all || (inv_one && inv_idx == TLB_IW'(g))) vld[g] <= 1'b0;
      else if (fill_en && fill_idx == TLB_IW'(g)) vld[g] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (fill_en && fill_idx == TLB_IW'(g)) ent[g] <= fill_ent;
      else if (chg_en && chg_idx == TLB_IW'(g)) ent[g].chg <= 1'b1;
    end
  end

  assign rd_vld = vld[rd_idx];
  assign rd_ent = ent[rd_idx];

  AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !rd_vld); // R10
endmodule

// File: rtl/hashed_xlate.sv
module hashed_xlate import hx_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [EA_W-1:0]   req_ea,
  input  logic [1:0]        req_acc,
  input  logic              problem_state,
  input  logic [EA_W-1:0]   cfg_origin,
  input  logic [HASH_W-1:0] cfg_mask,
  input  logic              sr_we,
  input  logic [SEG_IW-1:0] sr_idx,
  input  logic [SEG_BW-1:0] sr_wdata,
  input  logic              inv_one,
  input  logic              inv_all,
  input  logic [TLB_IW-1:0] inv_idx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [EA_W-1:0]   mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic [EA_W-1:0]   ra,
  output logic [1:0]        fault
);
  st_e                st;
  logic [EA_W-1:0]    ea_q;
  acc_e               acc_q;
  logic               ps_q;
  logic               pass_q;
  logic [SLOT_IW-1:0] slot_q;
  logic [31:0]        w1_q;
  logic               done_q;
  logic [EA_W-1:0]    ra_q;
  flt_e               flt_q;

  seg_t seg_ent;
  tlb_t tlb_ent;
  logic tlb_vld;

  hx_seg_file u_seg (
    .clk(clk), .rst_n(rst_n), .we(sr_we), .widx(sr_idx), .wdata(sr_wdata),
    .ridx(ea_q[EA_W-1 -: SEG_IW]), .rd(seg_ent)
  );

  // Named internal events used by the FSM and the assertions
  logic [PAGE_W-1:0] page_q;
  logic [EA_W-1:0]   pte0_addr;
  logic              nx_block, tlb_hit, pte_hit, perm_ok, need_chg;
  logic              fill_en, chg_en;
  tlb_t              fill_ent;

  assign page_q    = ea_q[12 +: PAGE_W];
  assign pte0_addr = f_group(cfg_origin, cfg_mask, f_hash(seg_ent.vsid, page_q, pass_q))
                     | (EA_W'(slot_q) << 3);
  assign nx_block  = (acc_q == ACC_FETCH) && seg_ent.nx;
  assign tlb_hit   = tlb_vld && (tlb_ent.vsid == seg_ent.vsid) && (tlb_ent.page == page_q);
  assign pte_hit   = f_pte_match(mem_rdata, seg_ent.vsid, ea_q[27:22], pass_q);
  assign perm_ok   = f_allowed(ps_q ? seg_ent.ku : seg_ent.ks, tlb_ent.pp, acc_q);
  assign need_chg  = (acc_q == ACC_WRITE) && !tlb_ent.chg;
  assign fill_en   = (st == S_RD1) && mem_ack;
  assign chg_en    = (st == S_WRC) && mem_ack;
  assign fill_ent  = '{vsid: seg_ent.vsid, page: page_q, rpn: mem_rdata[31:12],
                       chg: mem_rdata[CHG_BIT], pp: mem_rdata[1:0],
                       w1_addr: pte0_addr | EA_W'(4)};

  hx_page_tlb u_tlb (
    .clk(clk), .rst_n(rst_n), .rd_idx(ea_q[12 +: TLB_IW]), .rd_vld(tlb_vld), .rd_ent(tlb_ent),
    .fill_en(fill_en), .fill_idx(ea_q[12 +: TLB_IW]), .fill_ent(fill_ent),
    .chg_en(chg_en), .chg_idx(ea_q[12 +: TLB_IW]),
    .inv_one(inv_one), .inv_idx(inv_idx), .inv_all(inv_all)
  );

  always_comb begin
    mem_req = st inside {S_RD0, S_RD1, S_WRR, S_RDC, S_WRC};
    mem_we  = st inside {S_WRR, S_WRC};
    case (st)
      S_RD0:        mem_addr = pte0_addr;
      S_RD1, S_WRR: mem_addr = pte0_addr | EA_W'(4);
      default:      mem_addr = tlb_ent.w1_addr;
    endcase
    mem_wdata = w1_q | ((st == S_WRR) ? (32'd1 << REF_BIT) : (32'd1 << CHG_BIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ea_q <= '0; acc_q <= ACC_READ; ps_q <= 1'b0; pass_q <= 1'b0;
      slot_q <= '0; w1_q <= '0; done_q <= 1'b0; ra_q <= '0; flt_q <= FLT_NONE;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          ea_q <= req_ea; acc_q <= acc_e'(req_acc); ps_q <= problem_state; st <= S_CHECK;
        end
        S_CHECK:
          if (nx_block) begin
            done_q <= 1'b1; flt_q <= FLT_PROT; ra_q <= '0; st <= S_IDLE;
          end else if (tlb_hit) st <= S_PERM;
          else begin
            pass_q <= 1'b0; slot_q <= '0; st <= S_RD0;
          end
        S_RD0: if (mem_ack) begin
          if (pte_hit) st <= S_RD1;
          else if (slot_q == SLOT_IW'(SLOTS - 1)) begin
            if (pass_q) begin
              done_q <= 1'b1; flt_q <= FLT_MISS; ra_q <= '0; st <= S_IDLE;
            end else begin
              pass_q <= 1'b1; slot_q <= '0;
            end
          end else slot_q <= slot_q + 1'b1;
        end
        S_RD1: if (mem_ack) begin
          w1_q <= mem_rdata;
          st   <= mem_rdata[REF_BIT] ? S_PERM : S_WRR;
        end
        S_WRR: if (mem_ack) st <= S_PERM;
        S_PERM:
          if (!perm_ok) begin
            done_q <= 1'b1; flt_q <= FLT_PROT; ra_q <= '0; st <= S_IDLE;
          end else if (need_chg) st <= S_RDC;
          else begin
            done_q <= 1'b1; flt_q <= FLT_NONE; ra_q <= {tlb_ent.rpn, ea_q[11:0]}; st <= S_IDLE;
          end
        S_RDC: if (mem_ack) begin
          w1_q <= mem_rdata; st <= S_WRC;
        end
        S_WRC: if (mem_ack) begin
          done_q <= 1'b1; flt_q <= FLT_NONE; ra_q <= {tlb_ent.rpn, ea_q[11:0]}; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done  = done_q;
  assign ra    = ra_q;
  assign fault = flt_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !mem_req); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_NX_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && acc_q == ACC_FETCH && seg_ent.nx) |-> (fault == FLT_PROT)); // R2
  AST_RA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == FLT_NONE) |-> (ra[11:0] == ea_q[11:0])); // R9
  AST_MISS_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == FLT_MISS) |-> pass_q); // R4
  AST_WB_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[REF_BIT] && mem_addr[2])); // R6
endmodule

// File: tb/hashed_xlate_tb.sv
module hashed_xlate_tb;
  localparam logic [31:0] ORIGIN = 32'h0010_0000;
  localparam logic [18:0] HMASK  = 19'h003FF;
  localparam int LAT = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req_valid, problem_state, sr_we, inv_one, inv_all;
  logic [31:0] req_ea;
  logic [1:0]  req_acc;
  logic [3:0]  sr_idx;
  logic [26:0] sr_wdata;
  logic [5:0]  inv_idx;
  logic        mem_req, mem_we, mem_ack, done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, ra;
  logic [1:0]  fault;

  hashed_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea), .req_acc(req_acc),
    .problem_state(problem_state), .cfg_origin(ORIGIN), .cfg_mask(HMASK),
    .sr_we(sr_we), .sr_idx(sr_idx), .sr_wdata(sr_wdata),
    .inv_one(inv_one), .inv_all(inv_all), .inv_idx(inv_idx),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .ra(ra), .fault(fault)
  );

  int total = 0, bad = 0, n_acc = 0, lat = 0;
  bit outstanding = 0;
  logic [31:0] got_ra;
  logic [1:0]  got_flt;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] ref_mem [logic [31:0]];

  // reference state
  bit [23:0] m_vsid [16];
  bit m_ks [16], m_ku [16], m_nx [16];
  bit t_v [64];
  bit [23:0] t_vsid [64];
  bit [15:0] t_pg [64];
  bit [19:0] t_rpn [64];
  bit t_c [64];
  bit [1:0] t_pp [64];
  bit [31:0] t_a [64];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_ref(input logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] grp_addr(input bit [23:0] vsid, input bit [15:0] pg, input bit sec);
    int h;
    h = (int'(vsid) % 524288) ^ int'(pg);
    if (sec) h = 524287 - h;
    return ORIGIN + 32'((h & int'(HMASK)) * 64);
  endfunction

  function automatic bit may_do(input bit key, input bit [1:0] pp, input bit [1:0] acc);
    case ({key, pp})
      3'b011, 3'b101, 3'b111: return acc != 2'd1;
      3'b100:                 return 1'b0;
      default:                return 1'b1;
    endcase
  endfunction

  task automatic put_pte(input bit [23:0] vsid, input logic [31:0] ea, input bit hsel,
                         input bit sec, input int slot, input bit [19:0] rpn,
                         input bit r, input bit c, input bit [1:0] pp, input bit api_bad);
    logic [31:0] a, w0, w1;
    a  = grp_addr(vsid, ea[27:12], sec) + 32'(slot * 8);
    w0 = {1'b1, vsid, hsel, ea[27:22] ^ {5'b0, api_bad}};
    w1 = {rpn, 3'b000, r, c, 5'b00000, pp};
    mem[a] = w0; mem[a + 4] = w1;
    ref_mem[a] = w0; ref_mem[a + 4] = w1;
  endtask

  task automatic model(input logic [31:0] ea, input bit [1:0] acc, input bit ps,
                       output logic [31:0] e_ra, output logic [1:0] e_flt, output int e_cnt);
    int s, i;
    bit found;
    bit [23:0] vs;
    logic [31:0] a, w0, w1;
    s = int'(ea[31:28]); i = int'(ea[17:12]); vs = m_vsid[s];
    e_cnt = 0; e_ra = 32'h0;
    if (acc == 2'd2 && m_nx[s]) begin e_flt = 2'd1; return; end
    if (!(t_v[i] && t_vsid[i] == vs && t_pg[i] == ea[27:12])) begin
      found = 0;
      for (int p = 0; p < 2; p++)
        for (int sl = 0; sl < 8; sl++)
          if (!found) begin
            a = grp_addr(vs, ea[27:12], p[0]) + 32'(sl * 8);
            e_cnt++;
            w0 = rd_ref(a);
            if (w0[31] && w0[6] == p[0] && w0[30:7] == vs && w0[5:0] == ea[27:22]) begin
              found = 1; e_cnt++;
              w1 = rd_ref(a + 4);
              t_v[i] = 1; t_vsid[i] = vs; t_pg[i] = ea[27:12]; t_rpn[i] = w1[31:12];
              t_c[i] = w1[7]; t_pp[i] = w1[1:0]; t_a[i] = a + 4;
              if (!w1[8]) begin e_cnt++; ref_mem[a + 4] = w1 | 32'h100; end
            end
          end
      if (!found) begin e_flt = 2'd2; return; end
    end
    if (!may_do(ps ? m_ku[s] : m_ks[s], t_pp[i], acc)) begin e_flt = 2'd1; return; end
    if (acc == 2'd1 && !t_c[i]) begin
      e_cnt += 2; ref_mem[t_a[i]] = rd_ref(t_a[i]) | 32'h80; t_c[i] = 1;
    end
    e_ra = {t_rpn[i], ea[11:0]}; e_flt = 2'd0;
  endtask

  task automatic xact(input logic [31:0] ea, input bit [1:0] acc, input bit ps,
                      input string req, input bit poke);
    logic [31:0] e_ra;
    logic [1:0]  e_flt;
    int e_cnt, mism;
    model(ea, acc, ps, e_ra, e_flt, e_cnt);
    @(negedge clk);
    req_valid = 1; req_ea = ea; req_acc = acc; problem_state = ps;
    n_acc = 0; outstanding = 1;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      @(negedge clk);
      req_valid = 1; req_ea = 32'h0FFF_F000; req_acc = 2'd1;
      @(negedge clk);
      req_valid = 0;
    end
    while (outstanding) @(negedge clk);
    repeat (3) @(negedge clk);
    check(got_flt == e_flt, req, "fault", got_flt, e_flt);
    if (e_flt == 2'd0) check(got_ra == e_ra, req, "real address", got_ra, e_ra);
    check(n_acc == e_cnt, req, "memory accesses", n_acc, e_cnt);
    mism = 0;
    foreach (ref_mem[a]) if (!mem.exists(a) || mem[a] !== ref_mem[a]) mism++;
    check(mism == 0, req, "table words differing", mism, 0);
  endtask

  task automatic wr_sr(input int i, input bit ks, input bit ku, input bit nx, input bit [23:0] v);
    @(negedge clk);
    sr_we = 1; sr_idx = 4'(i); sr_wdata = {ks, ku, nx, v};
    @(negedge clk);
    sr_we = 0;
    m_vsid[i] = v; m_ks[i] = ks; m_ku[i] = ku; m_nx[i] = nx;
  endtask

  task automatic do_inv(input bit all, input logic [31:0] ea);
    @(negedge clk);
    inv_all = all; inv_one = !all; inv_idx = ea[17:12];
    @(negedge clk);
    inv_all = 0; inv_one = 0;
    if (all) foreach (t_v[k]) t_v[k] = 0;
    else t_v[ea[17:12]] = 0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  localparam logic [31:0] EA_A = 32'h0123_4ABC, EA_B = 32'h0456_7010, EA_F = 32'h1000_3000;

  initial begin
    rst_n = 0; req_valid = 0; req_ea = 0; req_acc = 0; problem_state = 0;
    sr_we = 0; sr_idx = 0; sr_wdata = 0; inv_one = 0; inv_all = 0; inv_idx = 0;
    mem_ack = 0; mem_rdata = 0;
    fork
      begin : responder
        forever begin
          @(posedge clk);
          mem_ack <= 1'b0;
          if (mem_req && !mem_ack) begin
            if (lat == LAT) begin
              lat = 0; mem_ack <= 1'b1; n_acc++;
              if (mem_we) mem[mem_addr] = mem_wdata;
              else mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            end else lat++;
          end
        end
      end
      begin : monitor
        forever begin
          @(negedge clk);
          if (rst_n && done) begin
            if (!outstanding) check(1'b0, "R11", "done without pending request", 1, 0);
            else begin got_ra = ra; got_flt = fault; outstanding = 0; end
          end
        end
      end
      begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "WD", "watchdog expired", 1, 0);
        finish_run();
      end
      begin : main
        repeat (3) @(negedge clk);
        check(done == 0 && mem_req == 0, "R11", "reset outputs quiet", {done, mem_req}, 0);
        rst_n = 1;
        wr_sr(0, 0, 0, 0, 24'h000123);
        wr_sr(1, 0, 1, 0, 24'h0ABCDE);
        wr_sr(2, 0, 0, 1, 24'h000777);
        wr_sr(3, 1, 0, 0, 24'h055555);
        // page tables
        put_pte(24'h000123, EA_A, 0, 0, 0, 20'hAAAAA, 0, 0, 2'b00, 0);
        put_pte(24'h000123, EA_B, 1, 1, 5, 20'h12345, 1, 1, 2'b00, 0);
        put_pte(24'h000123, 32'h0ABC_D000, 1, 0, 2, 20'h0DEAD, 1, 1, 2'b00, 0);
        put_pte(24'h000123, 32'h0ABC_D000, 0, 0, 1, 20'h0BEEF, 1, 1, 2'b00, 1);
        put_pte(24'h000777, 32'h2000_1000, 0, 0, 0, 20'h22222, 1, 1, 2'b10, 0);
        put_pte(24'h0ABCDE, EA_F, 0, 0, 0, 20'h33333, 1, 1, 2'b01, 0);
        put_pte(24'h055555, 32'h3000_4000, 0, 0, 0, 20'h44444, 1, 1, 2'b00, 0);
        put_pte(24'h055555, 32'h3000_5000, 0, 0, 3, 20'h55555, 0, 0, 2'b10, 0);
        put_pte(24'h055555, 32'h3000_7000, 0, 0, 7, 20'h77777, 1, 1, 2'b11, 0);
        put_pte(24'h000123, 32'h0000_6000, 0, 0, 0, 20'h66666, 1, 1, 2'b11, 0);

        xact(EA_A, 0, 0, "R6 R9 primary walk sets referenced", 0);
        xact(EA_A, 0, 0, "R3 TLB hit no table access", 0);
        xact(EA_A, 1, 0, "R8 first write sets changed", 0);
        xact(EA_A, 1, 0, "R8 second write no access", 0);
        xact(EA_B, 0, 0, "R4 secondary pass slot5 with ignored request R11", 1);
        xact(32'h0789_A000, 0, 0, "R9 miss both passes", 0);
        xact(32'h0ABC_D000, 0, 0, "R5 hash-select and api mismatch miss", 0);
        xact(32'h2000_1000, 2, 0, "R2 no-execute fetch", 0);
        xact(32'h2000_1000, 0, 0, "R2 R1 read through no-execute segment", 0);
        xact(EA_F, 1, 1, "R7 user key1 pp01 write denied", 0);
        xact(EA_F, 0, 1, "R7 user key1 pp01 read", 0);
        xact(EA_F, 1, 0, "R7 R1 supervisor key0 pp01 write", 0);
        xact(32'h3000_4000, 0, 0, "R7 key1 pp00 read denied", 0);
        xact(32'h3000_5000, 1, 0, "R7 R8 key1 pp10 write", 0);
        xact(32'h3000_7000, 0, 0, "R7 key1 pp11 read", 0);
        xact(32'h3000_7000, 1, 0, "R7 key1 pp11 write denied", 0);
        xact(32'h0000_6000, 1, 0, "R7 key0 pp11 write denied", 0);

        put_pte(24'h000123, EA_A, 0, 0, 0, 20'hBBBBB, 1, 1, 2'b00, 0);
        xact(EA_A, 0, 0, "R10 stale entry before invalidate", 0);
        do_inv(0, EA_A);
        xact(EA_A, 0, 0, "R10 invalidate-one refetch", 0);
        xact(EA_F, 0, 0, "R10 other entry kept", 0);
        put_pte(24'h000123, EA_B, 1, 1, 5, 20'hCCCCC, 1, 1, 2'b00, 0);
        xact(EA_B, 0, 0, "R10 stale before invalidate-all", 0);
        do_inv(1, EA_B);
        xact(EA_B, 0, 0, "R10 invalidate-all refetch", 0);
        xact(EA_F, 0, 1, "R10 invalidate-all cleared other", 0);
        finish_run();
      end
    join_any
  end
endmodule